// File: doc/BRIEF.md
# Multi-mode 16-bit timer counter

A 16-bit counter whose counting sequence is picked by a 4-bit waveform mode input. Each mode chooses where the count turns around (its TOP), whether it counts up only or up and then down, at what moment the two buffered compare values are copied into the active compare registers, and at which count the sticky overflow flag is raised. The block advances only on clock cycles where a one-cycle count-enable tick is high, so a prescaler in front of it sets the counting rate.

Around it, a downstream waveform output unit uses the per-channel compare-match strobes, the TOP and BOTTOM event strobes and the direction bit to drive its pins. Software-visible registers are outside this block: the compare values and the TOP value for capture-style modes arrive as plain inputs, and the overflow flag is cleared by a write-one-to-clear pulse.

The single-slope modes wrap to 0 after TOP. The dual-slope modes rise from 0 to TOP and fall back to 0, holding each end value for exactly one tick. Mode 13 is reserved: an error output is raised and the counter holds.

Top module: `wave_timer`

## Requirements
- R1: After reset the count, the direction bit, the overflow flag and both active compare registers are 0.
- R2: TOP is 0xFFFF in mode 0. It is 0x00FF in modes 1 and 5, 0x01FF in modes 2 and 6, and 0x03FF in modes 3 and 7. It is the capTop input in modes 8, 10, 12 and 14, and the active compare A register in modes 4, 9, 11 and 15.
- R3: In modes 0, 4, 5, 6, 7, 12, 14 and 15 (single slope), a tick moves the count to 0 when it equals TOP and increments it otherwise; countDown is 0 after any such tick.
- R4: In modes 1, 2, 3, 8, 9, 10 and 11 (dual slope), a tick increments the count while rising below TOP. At a count at or above TOP it decrements and sets countDown to 1. While falling it decrements, and at 0 it goes to 1 and clears countDown. When TOP is 0 the count stays at 0 with countDown 0.
- R5: A cycle with tick low changes neither the count nor countDown, and it loads the active compare registers only in modes 0, 4 and 12.
- R6: The active compare registers copy cmpA and cmpB on every clock in modes 0, 4 and 12. They copy them on a tick at count == TOP in modes 1, 2, 3, 10 and 11, and on a tick at count == 0 in modes 5, 6, 7, 8, 9, 14 and 15.
- R7: matchA (matchB) is high in a cycle exactly when tick is high, the mode is not 13, and the count equals the active compare A (B) register.
- R8: atTop (atBottom) is high in a cycle exactly when tick is high, the mode is not 13, and the count equals TOP (0).
- R9: ovfFlag becomes 1 on the clock after a tick with the count at 0xFFFF in modes 0, 4 and 12, at TOP in modes 5, 6, 7, 14 and 15, and at 0 in the dual-slope modes; it then stays 1 until cleared.
- R10: A high ovfClr clears ovfFlag on the next clock unless a set condition of R9 occurs in the same cycle, in which case the flag is 1.
- R11: In mode 13 modeErr is 1; the count, countDown and the active compare registers hold, no overflow is set, and all four strobes stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one cycle per count step |
| mode | input | 4 | Waveform mode select |
| cmpA | input | 16 | Compare value A, buffered |
| cmpB | input | 16 | Compare value B, buffered |
| capTop | input | 16 | TOP value for capture-register modes |
| ovfClr | input | 1 | Write-one-to-clear of the overflow flag |
| count | output | 16 | Counter value |
| countDown | output | 1 | 1 while the dual-slope count is falling |
| matchA | output | 1 | Compare-match strobe, channel A |
| matchB | output | 1 | Compare-match strobe, channel B |
| atTop | output | 1 | Strobe on a tick at TOP |
| atBottom | output | 1 | Strobe on a tick at 0 |
| ovfFlag | output | 1 | Sticky overflow flag |
| modeErr | output | 1 | Reserved mode selected |

## Verification
Every one of the sixteen modes is driven with a random tick gap and compare values that change at random moments. A change that lands inside a period shows whether each compare buffer copies at its own update point rather than at once. Small capTop and compare-A TOP values, including 0 and 1, separate the wrap rule of single slope from the turn rule of dual slope and expose the one-tick dwell at each end. One long mode 0 run at full tick rate reaches 0xFFFF, so the overflow set at MAX can be told apart from the set at TOP or at BOTTOM. Random ovfClr pulses sometimes coincide with a set event, which checks that the set wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {TOP_FIXED, TOP_CMPA, TOP_CAP} topSrc_t;
  typedef enum logic [1:0] {UPD_NOW, UPD_TOP, UPD_BOT, UPD_NONE} updAt_t;
  typedef enum logic [1:0] {OVF_MAX, OVF_TOP, OVF_BOT} ovfAt_t;

  // fixedSel: 0 = 8-bit, 1 = 9-bit, 2 = 10-bit, 3 = full width
  typedef struct packed {
    logic    dual;
    logic    reserved;
    topSrc_t topSrc;
    logic [1:0] fixedSel;
    updAt_t  updAt;
    ovfAt_t  ovfAt;
  } modeInfo_t;

  // strobes from control to datapath
  typedef struct packed {
    logic inc;
    logic dec;
    logic clr;
    logic loadBuf;
    logic setOvf;
  } tmrCtl_t;

  function automatic modeInfo_t decodeMode(input logic [3:0] m);
    modeInfo_t r;
    r = '{dual: 1'b0, reserved: 1'b0, topSrc: TOP_FIXED, fixedSel: 2'd3,
          updAt: UPD_NOW, ovfAt: OVF_MAX};
    case (m)
      4'd0: ;
      4'd1, 4'd2, 4'd3: begin
        r.dual = 1'b1; r.fixedSel = m[1:0] - 2'd1;
        r.updAt = UPD_TOP; r.ovfAt = OVF_BOT;
      end
      4'd4: r.topSrc = TOP_CMPA;
      4'd5, 4'd6, 4'd7: begin
        r.fixedSel = m[1:0] - 2'd1; r.updAt = UPD_BOT; r.ovfAt = OVF_TOP;
      end
      4'd8, 4'd9: begin
        r.dual = 1'b1; r.topSrc = m[0] ? TOP_CMPA : TOP_CAP;
        r.updAt = UPD_BOT; r.ovfAt = OVF_BOT;
      end
      4'd10, 4'd11: begin
        r.dual = 1'b1; r.topSrc = m[0] ? TOP_CMPA : TOP_CAP;
        r.updAt = UPD_TOP; r.ovfAt = OVF_BOT;
      end
      4'd12: r.topSrc = TOP_CAP;
      4'd13: begin
        r.reserved = 1'b1; r.updAt = UPD_NONE;
      end
      default: begin
        r.topSrc = m[0] ? TOP_CMPA : TOP_CAP;
        r.updAt = UPD_BOT; r.ovfAt = OVF_TOP;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CntW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic [3:0]      mode,
  input  logic [CntW-1:0] count,
  input  logic [CntW-1:0] actA,
  input  logic [CntW-1:0] actB,
  input  logic [CntW-1:0] capTop,
  output tmrCtl_t         ctl,
  output logic            countDown,
  output logic            matchA,
  output logic            matchB,
  output logic            atTop,
  output logic            atBottom,
  output logic            modeErr
);

  localparam logic [CntW-1:0] Top8  = CntW'(255);
  localparam logic [CntW-1:0] Top9  = CntW'(511);
  localparam logic [CntW-1:0] Top10 = CntW'(1023);

  modeInfo_t       info;
  logic [CntW-1:0] topVal;
  logic            live, isTop, isBot, isMax, topZero, pastTop;
  logic            dirDown;

  assign info = decodeMode(mode);

  always_comb begin
    case (info.topSrc)
      TOP_CMPA: topVal = actA;
      TOP_CAP:  topVal = capTop;
      default: begin
        case (info.fixedSel)
          2'd0:    topVal = Top8;
          2'd1:    topVal = Top9;
          2'd2:    topVal = Top10;
          default: topVal = '1;
        endcase
      end
    endcase
  end

  assign live    = tick && !info.reserved;
  assign isTop   = (count == topVal);
  assign isBot   = (count == '0);
  assign isMax   = &count;
  assign topZero = (topVal == '0);
  assign pastTop = (count >= topVal);

  assign atTop    = live && isTop;
  assign atBottom = live && isBot;
  assign matchA   = live && (count == actA);
  assign matchB   = live && (count == actB);
  assign modeErr  = info.reserved;
  assign countDown = dirDown;

  always_comb begin
    ctl = '0;
    case (info.updAt)
      UPD_NOW: ctl.loadBuf = 1'b1;
      UPD_TOP: ctl.loadBuf = tick && isTop;
      UPD_BOT: ctl.loadBuf = tick && isBot;
      default: ctl.loadBuf = 1'b0;
    endcase
    if (live) begin
      if (!info.dual) begin
        if (isTop) ctl.clr = 1'b1;
        else       ctl.inc = 1'b1;
      end else if (topZero) begin
        ctl.clr = 1'b1;
      end else if (!dirDown) begin
        if (pastTop) ctl.dec = 1'b1;
        else         ctl.inc = 1'b1;
      end else begin
        if (isBot) ctl.inc = 1'b1;
        else       ctl.dec = 1'b1;
      end
      case (info.ovfAt)
        OVF_MAX: ctl.setOvf = isMax;
        OVF_TOP: ctl.setOvf = isTop;
        default: ctl.setOvf = isBot;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirDown <= 1'b0;
    end else if (live) begin
      if (!info.dual || topZero) dirDown <= 1'b0;
      else if (!dirDown && pastTop) dirDown <= 1'b1;
      else if (dirDown && isBot) dirDown <= 1'b0;
    end
  end

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    info.reserved |=> (count == $past(count))); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(count) && $stable(countDown))); // R5

  AST_SINGLE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (live && !info.dual && isTop) |=> (count == '0)); // R3

  AST_DUAL_TURN_UP: assert property (@(posedge clk) disable iff (!rstN)
    (live && info.dual && dirDown && isBot && !topZero) |=> (count == CntW'(1) && !countDown)); // R4

endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int CntW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  tmrCtl_t         ctl,
  input  logic [CntW-1:0] cmpA,
  input  logic [CntW-1:0] cmpB,
  input  logic            ovfClr,
  output logic [CntW-1:0] count,
  output logic [CntW-1:0] actA,
  output logic [CntW-1:0] actB,
  output logic            ovfFlag
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (ctl.clr) begin
      count <= '0;
    end else if (ctl.inc) begin
      count <= count + CntW'(1);
    end else if (ctl.dec) begin
      count <= count - CntW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actA <= '0;
      actB <= '0;
    end else if (ctl.loadBuf) begin
      actA <= cmpA;
      actB <= cmpB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ovfFlag <= 1'b0;
    else if (ctl.setOvf)  ovfFlag <= 1'b1;
    else if (ovfClr)      ovfFlag <= 1'b0;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag); // R9

  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr && !ctl.setOvf) |=> !ovfFlag); // R10

endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import tmr_pkg::*;
#(
  parameter int CntW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic [3:0]      mode,
  input  logic [CntW-1:0] cmpA,
  input  logic [CntW-1:0] cmpB,
  input  logic [CntW-1:0] capTop,
  input  logic            ovfClr,
  output logic [CntW-1:0] count,
  output logic            countDown,
  output logic            matchA,
  output logic            matchB,
  output logic            atTop,
  output logic            atBottom,
  output logic            ovfFlag,
  output logic            modeErr
);

  tmrCtl_t         ctl;
  logic [CntW-1:0] actA, actB;

  tmr_ctrl #(.CntW(CntW)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .mode(mode),
    .count(count), .actA(actA), .actB(actB), .capTop(capTop),
    .ctl(ctl), .countDown(countDown), .matchA(matchA), .matchB(matchB),
    .atTop(atTop), .atBottom(atBottom), .modeErr(modeErr)
  );

  tmr_dp #(.CntW(CntW)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmpA(cmpA), .cmpB(cmpB),
    .ovfClr(ovfClr), .count(count), .actA(actA), .actB(actB),
    .ovfFlag(ovfFlag)
  );

endmodule

// File: tb/tb_wave_timer.sv
`timescale 1ns/1ps
module tb_wave_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  mode = 4'd5;
  logic [15:0] cmpA = 16'd0, cmpB = 16'd0, capTop = 16'd0;
  logic        ovfClr = 1'b0;
  logic [15:0] count;
  logic        countDown, matchA, matchB, atTop, atBottom, ovfFlag, modeErr;

  always #4 clk = ~clk;

  wave_timer dut (
    .clk(clk), .rstN(rstN), .tick(tick), .mode(mode), .cmpA(cmpA),
    .cmpB(cmpB), .capTop(capTop), .ovfClr(ovfClr), .count(count),
    .countDown(countDown), .matchA(matchA), .matchB(matchB),
    .atTop(atTop), .atBottom(atBottom), .ovfFlag(ovfFlag), .modeErr(modeErr)
  );

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  // staged inputs, applied right after a falling edge
  logic [3:0]  nMode = 4'd5;
  logic [15:0] nA = 16'd0, nB = 16'd0, nCap = 16'd0;

  // reference state
  logic [15:0] mCnt = 16'd0, mA = 16'd0, mB = 16'd0;
  logic        mDown = 1'b0, mOvf = 1'b0;
  string       cntTag = "R1";

  task automatic checkEq(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit isDual(input logic [3:0] m);
    return m inside {4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11};
  endfunction

  // R2: TOP source per mode
  function automatic logic [15:0] topOf(input logic [3:0] m, input logic [15:0] a,
                                        input logic [15:0] cap);
    case (m)
      4'd1, 4'd5: return 16'h00FF;
      4'd2, 4'd6: return 16'h01FF;
      4'd3, 4'd7: return 16'h03FF;
      4'd4, 4'd9, 4'd11, 4'd15: return a;
      4'd8, 4'd10, 4'd12, 4'd14: return cap;
      default: return 16'hFFFF;
    endcase
  endfunction

  // R6 point: 0 every clock, 1 at TOP, 2 at 0, 3 never
  function automatic int updOf(input logic [3:0] m);
    if (m inside {4'd0, 4'd4, 4'd12}) return 0;
    if (m inside {4'd1, 4'd2, 4'd3, 4'd10, 4'd11}) return 1;
    if (m == 4'd13) return 3;
    return 2;
  endfunction

  // R9 set point
  function automatic bit ovfHit(input logic [3:0] m, input logic [15:0] c,
                                input logic [15:0] top);
    if (m inside {4'd0, 4'd4, 4'd12}) return c == 16'hFFFF;
    if (isDual(m)) return c == 16'h0000;
    return c == top;
  endfunction

  task automatic runCycle(input bit tk, input bit clr);
    logic [15:0] top, oCnt;
    logic        live, oDown;
    @(negedge clk);
    mode = nMode; cmpA = nA; cmpB = nB; capTop = nCap;
    tick = tk; ovfClr = clr;
    #1;
    live = tk && (mode != 4'd13);
    top  = topOf(mode, mA, capTop);
    checkEq(cntTag, "count", count, mCnt);
    checkEq("R4", "countDown", {15'd0, countDown}, {15'd0, mDown});
    checkEq("R7 R6", "matchA", {15'd0, matchA}, {15'd0, live && mCnt == mA});
    checkEq("R7 R6", "matchB", {15'd0, matchB}, {15'd0, live && mCnt == mB});
    checkEq("R8", "atTop", {15'd0, atTop}, {15'd0, live && mCnt == top});
    checkEq("R8", "atBottom", {15'd0, atBottom}, {15'd0, live && mCnt == 16'd0});
    checkEq("R9 R10", "ovfFlag", {15'd0, ovfFlag}, {15'd0, mOvf});
    checkEq("R11", "modeErr", {15'd0, modeErr}, {15'd0, mode == 4'd13});
    // next state of the reference
    oCnt = mCnt; oDown = mDown;
    case (updOf(mode))
      0: begin mA = cmpA; mB = cmpB; end
      1: if (tk && oCnt == top) begin mA = cmpA; mB = cmpB; end
      2: if (tk && oCnt == 16'd0) begin mA = cmpA; mB = cmpB; end
      default: ;
    endcase
    if (live && ovfHit(mode, oCnt, top)) mOvf = 1'b1;
    else if (clr) mOvf = 1'b0;
    if (live) begin
      if (!isDual(mode)) begin
        mDown = 1'b0;
        mCnt = (oCnt == top) ? 16'd0 : oCnt + 16'd1;
      end else if (top == 16'd0) begin
        mDown = 1'b0; mCnt = 16'd0;
      end else if (!oDown) begin
        if (oCnt >= top) begin mDown = 1'b1; mCnt = oCnt - 16'd1; end
        else mCnt = oCnt + 16'd1;
      end else begin
        if (oCnt == 16'd0) begin mDown = 1'b0; mCnt = 16'd1; end
        else mCnt = oCnt - 16'd1;
      end
    end
    if (mode == 4'd13) cntTag = "R11";
    else if (!tk) cntTag = "R5";
    else if (isDual(mode)) cntTag = "R4 R2";
    else cntTag = "R3 R2";
  endtask

  // one stretch in a mode; cmpSpan > 0 re-picks compare values at random
  task automatic phase(input logic [3:0] m, input logic [15:0] cap,
                       input logic [15:0] a, input logic [15:0] b,
                       input int cycles, input int tickPct, input int cmpSpan);
    nMode = m; nCap = cap; nA = a; nB = b;
    for (int i = 0; i < cycles; i++) begin
      if (cmpSpan > 0 && ($urandom % 200) == 0) begin
        nA = 16'($urandom % cmpSpan);
        nB = 16'($urandom % cmpSpan);
      end
      runCycle(($urandom % 100) < tickPct, ($urandom % 150) == 0);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    checkEq("R1", "count after reset", count, 16'd0);
    checkEq("R1", "countDown after reset", {15'd0, countDown}, 16'd0);
    checkEq("R1", "ovfFlag after reset", {15'd0, ovfFlag}, 16'd0);
    // R1: active compares are 0, mode 5 buffers, so a tick at 0 matches both
    nMode = 4'd5; nA = 16'd7; nB = 16'd9;
    runCycle(1'b1, 1'b0);
    // R3, R9 R10: mode 0 up to 0xFFFF at full rate
    phase(4'd0, 16'd0, 16'h1234, 16'hFFFF, 66000, 100, 0);
    // fast PWM fixed TOPs
    phase(4'd5, 16'd0, 16'd40, 16'd200, 2200, 92, 300);
    phase(4'd6, 16'd0, 16'd100, 16'd500, 2200, 92, 600);
    phase(4'd7, 16'd0, 16'd900, 16'd3, 2400, 95, 1100);
    // R4: phase correct fixed TOPs
    phase(4'd1, 16'd0, 16'd10, 16'd250, 4500, 95, 300);
    phase(4'd2, 16'd0, 16'd300, 16'd0, 4500, 95, 600);
    phase(4'd3, 16'd0, 16'd1000, 16'd1023, 4500, 98, 1100);
    // clear-on-compare
    phase(4'd4, 16'd0, 16'd20, 16'd7, 600, 80, 0);
    phase(4'd4, 16'd0, 16'd25, 16'd3, 600, 80, 30);
    phase(4'd12, 16'd17, 16'd4, 16'd17, 800, 80, 25);
    // capture / compare-A TOP modes
    phase(4'd8, 16'd13, 16'd5, 16'd13, 800, 85, 18);
    phase(4'd9, 16'd0, 16'd11, 16'd4, 800, 85, 0);
    phase(4'd9, 16'd0, 16'd11, 16'd4, 800, 85, 20);
    phase(4'd10, 16'd9, 16'd9, 16'd0, 800, 85, 14);
    phase(4'd11, 16'd0, 16'd14, 16'd14, 800, 85, 20);
    phase(4'd14, 16'd21, 16'd21, 16'd0, 800, 85, 28);
    phase(4'd15, 16'd0, 16'd16, 16'd8, 800, 85, 20);
    // R11: reserved mode holds
    phase(4'd13, 16'd5, 16'd3, 16'd2, 60, 90, 8);
    // R4: TOP of 0 and 1 in dual slope
    phase(4'd8, 16'd0, 16'd0, 16'd0, 40, 100, 0);
    phase(4'd10, 16'd1, 16'd1, 16'd0, 40, 100, 0);
    phase(4'd9, 16'd0, 16'd1, 16'd1, 40, 100, 0);
    // mixed random modes and values
    for (int p = 0; p < 40; p++) begin
      logic [3:0] rm;
      rm = 4'($urandom % 16);
      phase(rm, 16'($urandom % 40), 16'($urandom % 40), 16'($urandom % 40),
            300, 70 + int'($urandom % 30), 40);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule